// File: doc/BRIEF.md
# Serial Column Counter with Programmable Stop Boundaries

This block produces the column address for the serial side of a 256-entry split serial buffer. The buffer is two halves of 128 entries. The counter advances by one on every enabled serial clock. A programmable set of stop boundaries repeats inside each half. When the counter steps on a boundary, it does not increment. It jumps to a tap address saved by the most recent split transfer, and it raises a one-cycle hit pulse. Software uses this to read tiled memory in scan-line order. A 128-entry half can also be made to behave like a full-depth buffer by alternating split transfers.

A mode-set strobe carries a 4-bit stop code that selects the boundary spacing. A split-transfer strobe carries the 8-bit tap address. Neither carries a data stream, and both are plain control pins with no back-pressure. When either strobe is high on a clock edge, its value is taken on that edge. Only the counter and its boundary logic are built here.

Top module: `sam_stop_counter`

## Requirements
- R1: While rst_n is low, col_addr is 0 and stop_hit is 0. After reset, the stop setting is the 128-spacing one, so the boundaries are 127 and 255, and the saved tap is 0.
- R2: On an edge where sclk_en is low, col_addr keeps its value. stop_hit is 0 in the following cycle.
- R3: On an edge where sclk_en is high and col_addr is not on a boundary, col_addr becomes col_addr+1.
- R4: On an edge where mset_stb is high, mset_code selects the boundary spacing used from the next edge on. The codes are 4'b1111 for spacing 128, 4'b0111 for 64, 4'b0011 for 32 and 4'b0001 for 16.
- R5: Any other mset_code value gives the same setting as 4'b1111.
- R6: A value is on a boundary when its low 7 bits plus one is a multiple of the spacing. This holds in both halves, so 255 is always a boundary and 16-spacing also stops at 143, 159 and so on.
- R7: On an edge where sclk_en is high and col_addr is on a boundary, col_addr becomes the saved 8-bit tap, half-select bit included. stop_hit is 1 for exactly the following cycle.
- R8: On an edge where xfer_stb is high, xfer_tap replaces the saved tap. The latest tap is reused for every later reload until it is replaced. A tap written on the same edge as a reload only affects later reloads.
- R9: A mode-set on the same edge as an enabled step does not change that step. The step uses the setting that was in force before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mset_stb | input | 1 | Mode-set strobe: capture mset_code |
| mset_code | input | 4 | Stop code selecting boundary spacing |
| xfer_stb | input | 1 | Split-transfer strobe: capture xfer_tap |
| xfer_tap | input | 8 | Tap address to reload at boundaries |
| sclk_en | input | 1 | Serial clock enable: one step per enabled edge |
| col_addr | output | 8 | Current serial column address |
| stop_hit | output | 1 | One-cycle pulse after a tap reload |

## Verification
If the stored spacing is wrong, the first symptom is a reload at the wrong count or a missed one. That shows on col_addr and stop_hit within at most 128 enabled steps, and within 16 steps for the finest setting. A wrong saved tap stays hidden until the next boundary. It then shows as a bad col_addr in the cycle after the hit. A counter fault shows on col_addr in the very next enabled cycle. The bench therefore runs every setting long enough to cross several boundaries in both halves. It also mixes in strobes that land on the same edge as reloads.

// File: rtl/sam_stop_pkg.sv
`timescale 1ns/1ps
package sam_stop_pkg;

  localparam int CODE_W = 4;

  // Boundary spacing, expressed as the number of high bits of the
  // half-offset that are ignored when looking for a boundary.
  typedef enum logic [1:0] {
    SPAN_FULL    = 2'd0,
    SPAN_HALF    = 2'd1,
    SPAN_QUARTER = 2'd2,
    SPAN_EIGHTH  = 2'd3
  } span_e;

  function automatic span_e decode_code(input logic [CODE_W-1:0] code);
    case (code)
      4'b1111: decode_code = SPAN_FULL;
      4'b0111: decode_code = SPAN_HALF;
      4'b0011: decode_code = SPAN_QUARTER;
      4'b0001: decode_code = SPAN_EIGHTH;
      default: decode_code = SPAN_FULL;
    endcase
  endfunction

endpackage

// File: rtl/sam_stop_code_reg.sv
`timescale 1ns/1ps
module sam_stop_code_reg
  import sam_stop_pkg::*;
#(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic [CODE_W-1:0] set_code,
  output logic [HALF_W-1:0] ign_mask
);

  span_e span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= SPAN_FULL;
    end else if (set_stb) begin
      span_q <= decode_code(set_code);
    end
  end

  // High bits of the half offset that do not take part in the match.
  always_comb begin
    ign_mask = ~({HALF_W{1'b1}} >> span_q);
  end

endmodule

// File: rtl/sam_tap_reg.sv
`timescale 1ns/1ps
module sam_tap_reg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end

endmodule

// File: rtl/sam_col_counter.sv
`timescale 1ns/1ps
module sam_col_counter #(
  parameter int ADDR_W = 8,
  localparam int HALF_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [HALF_W-1:0] ign_mask,
  input  logic [ADDR_W-1:0] tap,
  output logic [ADDR_W-1:0] cnt,
  output logic              hit
);

  logic on_bnd;

  // The half-select bit never takes part, so boundaries repeat per half.
  always_comb begin
    on_bnd = &(cnt[HALF_W-1:0] | ign_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (step) begin
        if (on_bnd) begin
          cnt <= tap;
          hit <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sam_stop_counter.sv
`timescale 1ns/1ps
module sam_stop_counter
  import sam_stop_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mset_stb,
  input  logic [3:0]        mset_code,
  input  logic              xfer_stb,
  input  logic [ADDR_W-1:0] xfer_tap,
  input  logic              sclk_en,
  output logic [ADDR_W-1:0] col_addr,
  output logic              stop_hit
);

  localparam int HALF_W = ADDR_W - 1;

  logic [HALF_W-1:0] stop_mask;
  logic [ADDR_W-1:0] tap_q;

  sam_stop_code_reg #(.HALF_W(HALF_W)) code_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_stb  (mset_stb),
    .set_code (mset_code),
    .ign_mask (stop_mask)
  );

  sam_tap_reg #(.ADDR_W(ADDR_W)) tap_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (xfer_stb),
    .din   (xfer_tap),
    .dout  (tap_q)
  );

  sam_col_counter #(.ADDR_W(ADDR_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (sclk_en),
    .ign_mask (stop_mask),
    .tap      (tap_q),
    .cnt      (col_addr),
    .hit      (stop_hit)
  );

endmodule

// File: rtl/sam_stop_counter_chk.sv
`timescale 1ns/1ps
module sam_stop_counter_chk #(
  parameter int ADDR_W = 8,
  localparam int HALF_W = ADDR_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_en,
  input logic              xfer_stb,
  input logic [ADDR_W-1:0] xfer_tap,
  input logic [ADDR_W-1:0] col_addr,
  input logic              stop_hit,
  input logic [HALF_W-1:0] mask,
  input logic [ADDR_W-1:0] tap
);

  logic at_bnd;
  assign at_bnd = &(col_addr[HALF_W-1:0] | mask);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en |=> ($stable(col_addr) && !stop_hit));

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && !at_bnd) |=> (col_addr == $past(col_addr) + ADDR_W'(1)));

  // R7
  reload_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && at_bnd) |=> (stop_hit && col_addr == $past(tap)));

  // R6
  top_always_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && col_addr == {ADDR_W{1'b1}}) |=> stop_hit);

  // R5
  legal_setting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mask) <= 3 && mask == ~({HALF_W{1'b1}} >> $countones(mask))));

  // R8
  tap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |=> (tap == $past(xfer_tap)));

endmodule

bind sam_stop_counter sam_stop_counter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk_en  (sclk_en),
  .xfer_stb (xfer_stb),
  .xfer_tap (xfer_tap),
  .col_addr (col_addr),
  .stop_hit (stop_hit),
  .mask     (stop_mask),
  .tap      (tap_q)
);

// File: tb/sam_stop_counter_tb.sv
`timescale 1ns/1ps
module sam_stop_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mset_stb = 1'b0;
  logic [3:0] mset_code = 4'b0;
  logic       xfer_stb = 1'b0;
  logic [7:0] xfer_tap = 8'h0;
  logic       sclk_en = 1'b0;
  logic [7:0] col_addr;
  logic       stop_hit;

  always #2.5 clk = ~clk;

  sam_stop_counter #(.ADDR_W(8)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mset_stb  (mset_stb),
    .mset_code (mset_code),
    .xfer_stb  (xfer_stb),
    .xfer_tap  (xfer_tap),
    .sclk_en   (sclk_en),
    .col_addr  (col_addr),
    .stop_hit  (stop_hit)
  );

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference model
  int m_cnt = 0;
  int m_tap = 0;
  int m_span = 128;
  bit m_hit = 1'b0;

  function automatic int span_of(input logic [3:0] c);
    if (c == 4'b0111) return 64;
    if (c == 4'b0011) return 32;
    if (c == 4'b0001) return 16;
    return 128;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_tap = 0; m_span = 128; m_hit = 1'b0;
    end else begin
      m_hit = 1'b0;
      if (sclk_en) begin
        if (((m_cnt % 128) + 1) % m_span == 0) begin
          m_cnt = m_tap;
          m_hit = 1'b1;
        end else begin
          m_cnt = (m_cnt + 1) % 256;
        end
      end
      if (xfer_stb) m_tap = xfer_tap;
      if (mset_stb) m_span = span_of(mset_code);
    end
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (col_addr !== 8'(m_cnt) || stop_hit !== m_hit) begin
        failures++;
        $display("FAIL %s: col_addr=%0d stop_hit=%0b expected col_addr=%0d stop_hit=%0b",
                 cur_req, col_addr, stop_hit, m_cnt, m_hit);
      end
    end
  end

  task automatic run(input int n, input int en_pct, input int x_pct, input int m_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclk_en   = ($urandom_range(99) < en_pct);
      xfer_stb  = ($urandom_range(99) < x_pct);
      xfer_tap  = 8'($urandom_range(255));
      mset_stb  = ($urandom_range(99) < m_pct);
      mset_code = 4'($urandom_range(15));
    end
    @(negedge clk);
    sclk_en = 1'b0; xfer_stb = 1'b0; mset_stb = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] code);
    @(negedge clk);
    sclk_en = 1'b0; mset_stb = 1'b1; mset_code = code;
    @(negedge clk);
    mset_stb = 1'b0;
  endtask

  task automatic set_tap(input logic [7:0] t);
    @(negedge clk);
    sclk_en = 1'b0; xfer_stb = 1'b1; xfer_tap = t;
    @(negedge clk);
    xfer_stb = 1'b0;
  endtask

  initial begin
    // R1: reset values, then default boundaries 127/255 with tap 0
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run(140, 100, 0, 0);

    // R2: enable gaps hold the counter
    cur_req = "R2";
    run(200, 40, 0, 0);

    // R3: plain increment runs
    cur_req = "R3";
    set_tap(8'h20);
    run(120, 100, 0, 0);

    // R4: each listed code with a tap in each half
    cur_req = "R4";
    set_mode(4'b1111); set_tap(8'h05); run(300, 100, 0, 0);
    set_mode(4'b0111); set_tap(8'h90); run(300, 100, 0, 0);
    set_mode(4'b0011); set_tap(8'h41); run(300, 100, 0, 0);
    set_mode(4'b0001); set_tap(8'hA3); run(300, 100, 0, 0);

    // R5: unlisted codes fall back to the 128 spacing
    cur_req = "R5";
    set_mode(4'b1010); set_tap(8'h70); run(300, 100, 0, 0);
    set_mode(4'b0001); set_mode(4'b0000); set_tap(8'hF0); run(300, 100, 0, 0);

    // R6: boundaries in the upper half and across halves
    cur_req = "R6";
    set_mode(4'b0001); set_tap(8'hC0); run(200, 100, 0, 0);
    set_mode(4'b0011); set_tap(8'h7E); run(200, 100, 0, 0);

    // R7: repeated reloads of the same full 8-bit tap
    cur_req = "R7";
    set_mode(4'b0001); set_tap(8'hFE); run(100, 100, 0, 0);

    // R8: taps written at random, some on reload edges
    cur_req = "R8";
    set_mode(4'b0001);
    run(600, 85, 30, 0);

    // R9: mode-sets landing on steps and reloads
    cur_req = "R9";
    run(800, 90, 15, 20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule